// File: doc/BRIEF.md
# Indexed Display Register Front End

This block is the byte-wide register window of a display controller. A host reaches three register banks (sequencer, CRT timing and graphics) through index/data pairs: it writes a register number to a bank's index offset, then reads or writes the selected register through that bank's data offset. The programmed contents of every bank are presented in flattened form to the timing and scanout logic downstream.

A palette mask register sits at its own offset. Behind it is a pixel-mode register that has no address of its own. To reach it, the host reads the mask offset four times in a row and then writes to that offset. The written byte then lands in the pixel-mode register and the mask keeps its value. The block also decodes the pixel-mode byte into a colour-depth code for the pixel path.

Top module: `idxreg_front`

## Requirements
- R1: After reset all three bank indices, all bank registers, the unlock read counter and the pixel-mode register are zero, and the palette mask is 0xFF.
- R2: Offsets 0x04/0x05 are the sequencer index/data, 0x14/0x15 the CRT index/data and 0x0E/0x0F the graphics index/data. A read of an index offset returns the 8-bit index last written there.
- R3: A data read or write reaches the register in the same bank picked by that bank's latest index write. Index writes to one bank do not move the selection in another bank.
- R4: Bank sizes are 32 sequencer, 32 CRT and 16 graphics registers. A data access whose index is at or above the bank size reads 0x00 and writes nothing.
- R5: A read of offset 0x06 returns the palette mask, also while the unlock count is advancing. A write to 0x06 that does not follow at least four consecutive reads of 0x06 loads the mask.
- R6: A write to 0x06 that follows four consecutive reads of 0x06 loads the pixel-mode register and leaves the mask unchanged. The count then returns to zero, so the next write to 0x06 goes to the mask.
- R7: Any read or write of an offset other than 0x06 restarts the count of consecutive 0x06 reads. Cycles with no access leave the count unchanged.
- R8: More than four consecutive reads of 0x06 still leave the unlock armed for the next write.
- R9: Reads of unmapped offsets return 0x00, and writes to them change no register.
- R10: The depth code is 0 for pixel mode 0x00 (8 bpp), 1 for 0xC1 (16 bpp), 2 for 0xC5 (24/32 bpp) and 3 for any other value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe (a write wins if both are high) |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle bus_rd is high |
| seq_regs | output | 256 | Sequencer registers, register i at bits 8i+7:8i |
| crt_regs | output | 256 | CRT registers, same packing |
| gfx_regs | output | 128 | Graphics registers, same packing |
| pix_mask | output | 8 | Palette mask |
| pix_mode | output | 8 | Hidden pixel-mode register |
| pix_depth | output | 2 | Decoded colour-depth code |

## Verification
A wrong unlock count shows up one cycle later in two ways: a hidden write lands in the palette mask, or a mask write changes pix_mode. Both are seen on the pix_mask and pix_mode ports at the next edge. A stale or misrouted index shows on the next data read, and in the flattened bank outputs in the cycle after the write. The reference model compares every output on every clock, so such a fault is found within one access of its cause.

// File: rtl/idxreg_pkg.sv
package idxreg_pkg;

  localparam logic [7:0] OFS_SEQ_IDX = 8'h04;
  localparam logic [7:0] OFS_SEQ_DAT = 8'h05;
  localparam logic [7:0] OFS_MASK    = 8'h06;
  localparam logic [7:0] OFS_GFX_IDX = 8'h0E;
  localparam logic [7:0] OFS_GFX_DAT = 8'h0F;
  localparam logic [7:0] OFS_CRT_IDX = 8'h14;
  localparam logic [7:0] OFS_CRT_DAT = 8'h15;

  localparam logic [7:0] MODE_8BPP  = 8'h00;
  localparam logic [7:0] MODE_16BPP = 8'hC1;
  localparam logic [7:0] MODE_24BPP = 8'hC5;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_SEQ_I, SEL_SEQ_D, SEL_GFX_I, SEL_GFX_D,
    SEL_CRT_I, SEL_CRT_D, SEL_MASK
  } sel_e;

  typedef enum logic [1:0] {
    DEPTH_8 = 2'd0, DEPTH_16 = 2'd1, DEPTH_24_32 = 2'd2, DEPTH_OTHER = 2'd3
  } depth_e;

  function automatic sel_e decode_ofs(input logic [7:0] a);
    case (a)
      OFS_SEQ_IDX: return SEL_SEQ_I;
      OFS_SEQ_DAT: return SEL_SEQ_D;
      OFS_MASK:    return SEL_MASK;
      OFS_GFX_IDX: return SEL_GFX_I;
      OFS_GFX_DAT: return SEL_GFX_D;
      OFS_CRT_IDX: return SEL_CRT_I;
      OFS_CRT_DAT: return SEL_CRT_D;
      default:     return SEL_NONE;
    endcase
  endfunction

  function automatic depth_e depth_of(input logic [7:0] m);
    case (m)
      MODE_8BPP:  return DEPTH_8;
      MODE_16BPP: return DEPTH_16;
      MODE_24BPP: return DEPTH_24_32;
      default:    return DEPTH_OTHER;
    endcase
  endfunction

endpackage

// File: rtl/idx_bank.sv
module idx_bank #(
  parameter int REGS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              idx_we,
  input  logic              dat_we,
  input  logic [7:0]        wdata,
  output logic [7:0]        idx_q,
  output logic [7:0]        dat_q,
  output logic [REGS*8-1:0] regs_flat
);
  localparam int AW = (REGS > 1) ? $clog2(REGS) : 1;

  logic [7:0]    regs [REGS];
  logic          in_range;
  logic [AW-1:0] slot;

  assign in_range = (32'(idx_q) < REGS);
  assign slot     = idx_q[AW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n)      idx_q <= 8'h00;
    else if (idx_we) idx_q <= wdata;
  end

  for (genvar i = 0; i < REGS; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)
        regs[i] <= 8'h00;
      else if (dat_we && in_range && (slot == AW'(i)))
        regs[i] <= wdata;
    end
    assign regs_flat[i*8 +: 8] = regs[i];
  end

  assign dat_q = in_range ? regs[slot] : 8'h00;

endmodule

// File: rtl/hidden_unlock.sv
module hidden_unlock #(
  parameter int READS = 4,
  localparam int CW = $clog2(READS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mask_rd,
  input  logic          mask_wr,
  input  logic          other_acc,
  input  logic [7:0]    wdata,
  output logic [CW-1:0] cnt_q,
  output logic          hidden_wr,
  output logic [7:0]    mask_q,
  output logic [7:0]    mode_q
);
  logic armed;

  assign armed     = (cnt_q == CW'(READS));
  assign hidden_wr = mask_wr && armed;

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (mask_wr || other_acc)
      cnt_q <= '0;
    else if (mask_rd && !armed)
      cnt_q <= cnt_q + CW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                mask_q <= 8'hFF;
    else if (mask_wr && !armed) mask_q <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         mode_q <= 8'h00;
    else if (hidden_wr) mode_q <= wdata;
  end

endmodule

// File: rtl/idxreg_front.sv
module idxreg_front
  import idxreg_pkg::*;
#(
  parameter int SEQ_REGS     = 32,
  parameter int CRT_REGS     = 32,
  parameter int GFX_REGS     = 16,
  parameter int UNLOCK_READS = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [7:0]            bus_addr,
  input  logic [7:0]            bus_wdata,
  output logic [7:0]            bus_rdata,
  output logic [SEQ_REGS*8-1:0] seq_regs,
  output logic [CRT_REGS*8-1:0] crt_regs,
  output logic [GFX_REGS*8-1:0] gfx_regs,
  output logic [7:0]            pix_mask,
  output logic [7:0]            pix_mode,
  output logic [1:0]            pix_depth
);
  localparam int CNT_W = $clog2(UNLOCK_READS + 1);

  sel_e             sel;
  logic             rd_en;
  logic             mask_rd, mask_wr, other_acc, hidden_wr;
  logic [CNT_W-1:0] unlock_cnt;
  logic [7:0]       seq_idx, crt_idx, gfx_idx;
  logic [7:0]       seq_dat, crt_dat, gfx_dat;

  assign sel       = decode_ofs(bus_addr);
  assign rd_en     = bus_rd && !bus_wr;
  assign mask_rd   = rd_en  && (sel == SEL_MASK);
  assign mask_wr   = bus_wr && (sel == SEL_MASK);
  assign other_acc = (bus_wr || bus_rd) && (sel != SEL_MASK);

  idx_bank #(.REGS(SEQ_REGS)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .idx_we(bus_wr && sel == SEL_SEQ_I), .dat_we(bus_wr && sel == SEL_SEQ_D),
    .wdata(bus_wdata), .idx_q(seq_idx), .dat_q(seq_dat), .regs_flat(seq_regs)
  );

  idx_bank #(.REGS(CRT_REGS)) u_crt (
    .clk(clk), .rst_n(rst_n),
    .idx_we(bus_wr && sel == SEL_CRT_I), .dat_we(bus_wr && sel == SEL_CRT_D),
    .wdata(bus_wdata), .idx_q(crt_idx), .dat_q(crt_dat), .regs_flat(crt_regs)
  );

  idx_bank #(.REGS(GFX_REGS)) u_gfx (
    .clk(clk), .rst_n(rst_n),
    .idx_we(bus_wr && sel == SEL_GFX_I), .dat_we(bus_wr && sel == SEL_GFX_D),
    .wdata(bus_wdata), .idx_q(gfx_idx), .dat_q(gfx_dat), .regs_flat(gfx_regs)
  );

  hidden_unlock #(.READS(UNLOCK_READS)) u_unlock (
    .clk(clk), .rst_n(rst_n),
    .mask_rd(mask_rd), .mask_wr(mask_wr), .other_acc(other_acc),
    .wdata(bus_wdata), .cnt_q(unlock_cnt), .hidden_wr(hidden_wr),
    .mask_q(pix_mask), .mode_q(pix_mode)
  );

  always_comb begin
    bus_rdata = 8'h00;
    if (rd_en) begin
      case (sel)
        SEL_SEQ_I: bus_rdata = seq_idx;
        SEL_SEQ_D: bus_rdata = seq_dat;
        SEL_CRT_I: bus_rdata = crt_idx;
        SEL_CRT_D: bus_rdata = crt_dat;
        SEL_GFX_I: bus_rdata = gfx_idx;
        SEL_GFX_D: bus_rdata = gfx_dat;
        SEL_MASK:  bus_rdata = pix_mask;
        default:   bus_rdata = 8'h00;
      endcase
    end
  end

  assign pix_depth = depth_of(pix_mode);

endmodule

// File: rtl/idxreg_front_chk.sv
module idxreg_front_chk #(
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_wr,
  input logic             bus_rd,
  input logic [7:0]       bus_addr,
  input logic [7:0]       bus_wdata,
  input logic [7:0]       bus_rdata,
  input logic [7:0]       pix_mask,
  input logic [7:0]       pix_mode,
  input logic             hidden_wr,
  input logic             other_acc,
  input logic [CNT_W-1:0] unlock_cnt,
  input logic [7:0]       seq_idx,
  input logic [7:0]       crt_idx
);
  logic mapped;
  assign mapped = (bus_addr == 8'h04) || (bus_addr == 8'h05) || (bus_addr == 8'h06) ||
                  (bus_addr == 8'h0E) || (bus_addr == 8'h0F) ||
                  (bus_addr == 8'h14) || (bus_addr == 8'h15);

  a_r2_seq_index_load: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 8'h04) |=> seq_idx == $past(bus_wdata));

  a_r2_crt_index_load: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 8'h14) |=> crt_idx == $past(bus_wdata));

  a_r5_mask_read_value: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr && bus_addr == 8'h06) |-> bus_rdata == pix_mask);

  a_r6_hidden_keeps_mask: assert property (@(posedge clk) disable iff (!rst_n)
    hidden_wr |=> $stable(pix_mask));

  a_r6_hidden_rearms: assert property (@(posedge clk) disable iff (!rst_n)
    hidden_wr |=> unlock_cnt == '0);

  a_r6_mode_only_hidden: assert property (@(posedge clk) disable iff (!rst_n)
    !hidden_wr |=> $stable(pix_mode));

  a_r7_other_clears: assert property (@(posedge clk) disable iff (!rst_n)
    other_acc |=> unlock_cnt == '0);

  a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr && !mapped) |-> bus_rdata == 8'h00);

endmodule

bind idxreg_front idxreg_front_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .pix_mask(pix_mask), .pix_mode(pix_mode), .hidden_wr(hidden_wr),
  .other_acc(other_acc), .unlock_cnt(unlock_cnt),
  .seq_idx(seq_idx), .crt_idx(crt_idx)
);

// File: tb/tb_idxreg_front.sv
module tb_idxreg_front;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]   bus_addr = 8'h00, bus_wdata = 8'h00;
  logic [7:0]   bus_rdata;
  logic [255:0] seq_regs, crt_regs;
  logic [127:0] gfx_regs;
  logic [7:0]   pix_mask, pix_mode;
  logic [1:0]   pix_depth;

  int checks = 0, failures = 0;
  bit mon_on = 1'b0;

  // behavioural reference state
  logic [7:0] m_seq [32];
  logic [7:0] m_crt [32];
  logic [7:0] m_gfx [16];
  logic [7:0] m_si = 0, m_ci = 0, m_gi = 0, m_mask = 8'hFF, m_mode = 0;
  int         m_reads = 0;

  always #5 clk = ~clk;

  idxreg_front dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .seq_regs(seq_regs), .crt_regs(crt_regs), .gfx_regs(gfx_regs),
    .pix_mask(pix_mask), .pix_mode(pix_mode), .pix_depth(pix_depth)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_read(input logic [7:0] a);
    if (a == 8'h04) return m_si;
    if (a == 8'h14) return m_ci;
    if (a == 8'h0E) return m_gi;
    if (a == 8'h05) return (m_si < 32) ? m_seq[m_si] : 8'h00;
    if (a == 8'h15) return (m_ci < 32) ? m_crt[m_ci] : 8'h00;
    if (a == 8'h0F) return (m_gi < 16) ? m_gfx[m_gi] : 8'h00;
    if (a == 8'h06) return m_mask;
    return 8'h00;
  endfunction

  function automatic int ref_depth(input logic [7:0] m);
    if (m == 8'h00) return 0;
    if (m == 8'hC1) return 1;
    if (m == 8'hC5) return 2;
    return 3;
  endfunction

  task automatic ref_write(input logic [7:0] a, input logic [7:0] d);
    if (a == 8'h06) begin
      if (m_reads >= 4) m_mode = d;
      else              m_mask = d;
    end
    else if (a == 8'h04) m_si = d;
    else if (a == 8'h14) m_ci = d;
    else if (a == 8'h0E) m_gi = d;
    else if (a == 8'h05 && m_si < 32) m_seq[m_si] = d;
    else if (a == 8'h15 && m_ci < 32) m_crt[m_ci] = d;
    else if (a == 8'h0F && m_gi < 16) m_gfx[m_gi] = d;
    m_reads = 0;
  endtask

  task automatic access(input bit w, input logic [7:0] a, input logic [7:0] d, input string tag);
    @(negedge clk);
    bus_wr = w; bus_rd = !w; bus_addr = a; bus_wdata = d;
    #1;
    if (!w) chk(bus_rdata == ref_read(a), tag, bus_rdata, ref_read(a));
    @(posedge clk);
    if (w) ref_write(a, d);
    else if (a == 8'h06) m_reads++;
    else m_reads = 0;
    #1;
    bus_wr = 1'b0; bus_rd = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d, input string tag);
    access(1'b1, a, d, tag);
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    access(1'b0, a, 8'h00, tag);
  endtask

  // per-clock comparison of the registered outputs against the model
  always @(negedge clk) begin
    if (mon_on) begin
      chk(pix_mask == m_mask, "R5 pix_mask", pix_mask, m_mask);
      chk(pix_mode == m_mode, "R6 pix_mode", pix_mode, m_mode);
      chk(int'(pix_depth) == ref_depth(m_mode), "R10 pix_depth", pix_depth, ref_depth(m_mode));
      for (int i = 0; i < 32; i++) begin
        chk(seq_regs[i*8 +: 8] == m_seq[i], "R3 seq_regs", seq_regs[i*8 +: 8], m_seq[i]);
        chk(crt_regs[i*8 +: 8] == m_crt[i], "R3 crt_regs", crt_regs[i*8 +: 8], m_crt[i]);
      end
      for (int i = 0; i < 16; i++)
        chk(gfx_regs[i*8 +: 8] == m_gfx[i], "R3 gfx_regs", gfx_regs[i*8 +: 8], m_gfx[i]);
    end
  end

  initial begin
    #1000000;
    checks++; failures++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) begin m_seq[i] = 0; m_crt[i] = 0; end
    for (int i = 0; i < 16; i++) m_gfx[i] = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    mon_on = 1'b1;

    // R1: reset state
    @(negedge clk);
    chk(pix_mask == 8'hFF, "R1 mask reset", pix_mask, 8'hFF);
    chk(pix_mode == 8'h00, "R1 mode reset", pix_mode, 8'h00);
    rd(8'h04, "R1 seq index reset");
    rd(8'h14, "R1 crt index reset");
    rd(8'h0E, "R1 gfx index reset");
    rd(8'h15, "R1 crt data reset");

    // R2 / R3: index then data in each bank
    wr(8'h04, 8'h07, "R2");  wr(8'h05, 8'h11, "R3");
    wr(8'h14, 8'h1B, "R2");  wr(8'h15, 8'h22, "R3");
    wr(8'h0E, 8'h06, "R2");  wr(8'h0F, 8'h05, "R3");
    rd(8'h04, "R2 seq index readback");
    rd(8'h14, "R2 crt index readback");
    rd(8'h0E, "R2 gfx index readback");
    rd(8'h05, "R3 seq data");
    rd(8'h15, "R3 crt data");
    rd(8'h0F, "R3 gfx data");
    wr(8'h14, 8'h1D, "R3");  wr(8'h15, 8'h80, "R3");
    rd(8'h05, "R3 seq unaffected by crt index");
    wr(8'h14, 8'h1B, "R3");
    rd(8'h15, "R3 crt reselect");

    // R4: out-of-range indices
    wr(8'h14, 8'h40, "R4");  wr(8'h15, 8'h99, "R4");
    rd(8'h15, "R4 crt out of range reads zero");
    wr(8'h0E, 8'h10, "R4");  wr(8'h0F, 8'h77, "R4");
    rd(8'h0F, "R4 gfx index 16 reads zero");
    wr(8'h04, 8'hFF, "R4");  rd(8'h05, "R4 seq index FF reads zero");

    // R5: plain mask write after fewer than four reads
    rd(8'h06, "R5 mask read"); rd(8'h06, "R5 mask read");
    wr(8'h06, 8'h3C, "R5");
    rd(8'h06, "R5 mask after write");

    // R6: unlock sequence
    for (int k = 0; k < 4; k++) rd(8'h06, "R5 mask read while counting");
    wr(8'h06, 8'hC1, "R6 hidden write");
    chk(pix_mode == 8'hC1, "R6 mode loaded", pix_mode, 8'hC1);
    chk(pix_mask == 8'h3C, "R6 mask kept", pix_mask, 8'h3C);
    chk(pix_depth == 2'd1, "R10 16bpp", pix_depth, 1);
    wr(8'h06, 8'h0F, "R6 rearm goes to mask");
    chk(pix_mask == 8'h0F, "R6 second write to mask", pix_mask, 8'h0F);

    // R7: interrupted sequences
    for (int k = 0; k < 3; k++) rd(8'h06, "R7");
    rd(8'h05, "R7 other read");
    rd(8'h06, "R7");
    wr(8'h06, 8'h12, "R7 interrupted by read");
    chk(pix_mask == 8'h12, "R7 mask got write", pix_mask, 8'h12);
    for (int k = 0; k < 3; k++) rd(8'h06, "R7");
    wr(8'h33, 8'h55, "R7 unmapped write");
    rd(8'h06, "R7");
    wr(8'h06, 8'h21, "R7 interrupted by write");
    chk(pix_mode == 8'hC1, "R7 mode untouched", pix_mode, 8'hC1);

    // R8: long read run still arms
    for (int k = 0; k < 6; k++) rd(8'h06, "R8");
    wr(8'h06, 8'hC5, "R8");
    chk(pix_mode == 8'hC5, "R8 mode after six reads", pix_mode, 8'hC5);
    chk(pix_depth == 2'd2, "R10 24/32bpp", pix_depth, 2);

    // R9: unmapped offsets
    wr(8'h30, 8'hAA, "R9");
    rd(8'h30, "R9 unmapped read zero");
    rd(8'h07, "R9 unmapped read zero");
    rd(8'hFF, "R9 unmapped read zero");

    // R10: other depth codes
    for (int k = 0; k < 4; k++) rd(8'h06, "R10");
    wr(8'h06, 8'h80, "R10");
    chk(pix_depth == 2'd3, "R10 other value", pix_depth, 3);
    for (int k = 0; k < 4; k++) rd(8'h06, "R10");
    wr(8'h06, 8'h00, "R10");
    chk(pix_depth == 2'd0, "R10 8bpp", pix_depth, 0);

    repeat (2) @(posedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule